// File: doc/BRIEF.md
# Fixed-Frequency PWM Gate with Cycle-by-Cycle Current Cutoff

This block produces the conduction permit for the low-side switches of a motor bridge. A free-running binary counter acts as the modulation ramp. Each time the counter wraps, a new period starts and two independent set/reset latches are set together. The permit output is high only while both latches hold.

The first latch clears when the ramp reaches the digital duty command. The second latch clears when the overcurrent comparator bit trips, after that bit has passed through a synchroniser. Once a latch has cleared, only the start of the next period can set it again. This gives at most one conduction pulse per period. A current trip keeps the switches off for the rest of that period, even if the overcurrent condition goes away.

A one-cycle strobe marks each period start. A fault flag shows the synchronised overcurrent level.

Top module: `dual_latch_pwm`

## Requirements
- R1: While rst_ni is low, permit_o, fault_o and cycle_start_o are all low. After release, permit_o stays low until the first cycle_start_o pulse.
- R2: The ramp period is 2^CNT_W clocks. cycle_start_o is high for exactly one clock per period, in the clock where the ramp count is 0.
- R3: For a duty command D (CNT_W+1 bits, 0 to 2^CNT_W) held through a period, permit_o rises in the cycle_start_o clock and stays high for exactly D consecutive clocks.
- R4: D = 0 gives no conduction in the period. D = 2^CNT_W keeps permit_o high through every clock, across period boundaries.
- R5: At most one conduction pulse occurs per period. Raising D after the pulse has ended does not restart conduction before the next period.
- R6: A high level on oc_i clears permit_o on the third rising clock edge after it is first sampled.
- R7: After a current trip, permit_o stays low for the rest of that period, even once oc_i has returned low. Normal conduction resumes at the next period start.
- R8: If the synchronised overcurrent is still high at a period start, no conduction occurs in that period, even if oc_i falls partway through the period.
- R9: fault_o follows oc_i delayed by two clock edges. It rises two clocks after oc_i goes high and falls two clocks after oc_i goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| duty_i | input | CNT_W+1 | Duty command in ramp steps, 0 to 2^CNT_W |
| oc_i | input | 1 | Overcurrent comparator bit, asynchronous |
| permit_o | output | 1 | Low-side conduction permit |
| fault_o | output | 1 | Synchronised overcurrent flag |
| cycle_start_o | output | 1 | One-clock strobe at each period start |

## Verification
A duty latch stuck set, or one that can be set again partway through a period, shows up at permit_o. Within the same period the pulse length stops matching D, or a second rising edge appears. A broken current latch, or a wrong synchroniser depth, shifts the trip point away from the third clock after oc_i rises, or lets conduction return before the next strobe. Because the strobe is checked against an exact 2^CNT_W spacing, a wrong ramp width or wrap point shows up within one period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // State of the two conduction latches; output permit is their AND
  typedef struct packed {
    logic duty_en;
    logic ilim_en;
  } latch_pair_t;
endpackage

// File: rtl/pwm_ramp.sv
module pwm_ramp #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             start_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  assign wrap_o = (cnt_o == CntMax);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o   <= '0;
      start_o <= 1'b0;
    end else begin
      cnt_o   <= cnt_o + 1'b1;
      start_o <= wrap_o;
    end
  end

  // R2
  start_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (cnt_o == '0));
endmodule

// File: rtl/oc_sync.sv
module oc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/pwm_latch_pair.sv
module pwm_latch_pair
  import pwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W:0]   duty_i,
  input  logic             oc_i,
  output logic             permit_o
);
  latch_pair_t st_q, st_d;
  logic [CNT_W-1:0] cnt_nxt;
  logic             duty_hit;

  assign cnt_nxt  = cnt_i + 1'b1;
  assign duty_hit = ({1'b0, cnt_nxt} >= duty_i);

  // Reset dominates set in both latches
  always_comb begin
    st_d.duty_en = st_q.duty_en | wrap_i;
    if (duty_hit) st_d.duty_en = 1'b0;
    st_d.ilim_en = st_q.ilim_en | wrap_i;
    if (oc_i) st_d.ilim_en = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign permit_o = st_q.duty_en & st_q.ilim_en;

  // R3
  permit_below_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    permit_o |-> ({1'b0, cnt_i} < $past(duty_i)));

  // R6
  oc_cuts_permit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(oc_i) |-> !permit_o);
endmodule

// File: rtl/dual_latch_pwm.sv
module dual_latch_pwm #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [CNT_W:0] duty_i,
  input  logic           oc_i,
  output logic           permit_o,
  output logic           fault_o,
  output logic           cycle_start_o
);
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic             oc_s;

  pwm_ramp #(.CNT_W(CNT_W)) ramp_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_o   (cnt),
    .wrap_o  (wrap),
    .start_o (cycle_start_o)
  );

  oc_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (oc_i),
    .q_o    (oc_s)
  );

  pwm_latch_pair #(.CNT_W(CNT_W)) latch_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wrap_i   (wrap),
    .cnt_i    (cnt),
    .duty_i   (duty_i),
    .oc_i     (oc_s),
    .permit_o (permit_o)
  );

  assign fault_o = oc_s;

  // R5
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (permit_o && !$past(permit_o)) |-> cycle_start_o);

  // R8
  blocked_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_start_o && $past(fault_o)) |-> !permit_o);
endmodule

// File: tb/dual_latch_pwm_tb_top.sv
module dual_latch_pwm_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int PER        = 1 << CNT_W;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic [CNT_W:0] duty = '0;
  logic           oc = 1'b0;
  logic           permit, fault, cstart;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_latch_pwm #(.CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .duty_i(duty), .oc_i(oc),
    .permit_o(permit), .fault_o(fault), .cycle_start_o(cstart)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Align to a strobe, then observe one full period with optional mid-period actions
  task automatic run_period(output int highs, output int pulses,
                            input int chg_at, input int new_duty,
                            input int oc_on, input int oc_off);
    int prev = 0;
    highs = 0; pulses = 0;
    while (!cstart) @(negedge clk);
    for (int i = 0; i < PER; i++) begin
      if (permit) highs++;
      if (permit && !prev) pulses++;
      prev = int'(permit);
      if (i == chg_at) duty = new_duty[CNT_W:0];
      if (i == oc_on)  oc = 1'b1;
      if (i == oc_off) oc = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    int seen = 0;
    check("R1 permit in reset", int'(permit), 0);
    check("R1 fault in reset", int'(fault), 0);
    check("R1 strobe in reset", int'(cstart), 0);
    duty = 9'd100;
    rst_ni = 1'b1;
    @(negedge clk);
    while (!cstart) begin
      if (permit) seen++;
      @(negedge clk);
    end
    check("R1 no permit before first strobe", seen, 0);
  endtask

  task automatic t_strobe_spacing();
    int gap = 0;
    int ones = 0;
    while (!cstart) @(negedge clk);
    @(negedge clk);
    while (!cstart) begin
      gap++;
      @(negedge clk);
    end
    check("R2 strobe spacing", gap + 1, PER);
    for (int i = 0; i < PER; i++) begin
      if (cstart) ones++;
      @(negedge clk);
    end
    check("R2 one strobe per period", ones, 1);
  endtask

  task automatic t_duty(int d, string tag);
    int h, p;
    duty = d[CNT_W:0];
    run_period(h, p, -1, 0, -1, -1);
    run_period(h, p, -1, 0, -1, -1);
    check({tag, " high count"}, h, d);
    check({tag, " pulse count"}, p, (d == 0) ? 0 : 1);
  endtask

  task automatic t_full_scale();
    int h1, p1, h2, p2;
    duty = PER[CNT_W:0];
    run_period(h1, p1, -1, 0, -1, -1);
    run_period(h1, p1, -1, 0, -1, -1);
    run_period(h2, p2, -1, 0, -1, -1);
    check("R4 full scale two periods", h1 + h2, 2 * PER);
  endtask

  task automatic t_one_pulse();
    int h, p;
    duty = 9'd50;
    run_period(h, p, -1, 0, -1, -1);
    run_period(h, p, 100, 200, -1, -1);
    check("R5 raised duty no restart highs", h, 50);
    check("R5 single pulse", p, 1);
    run_period(h, p, -1, 0, -1, -1);
    check("R5 new duty next period", h, 200);
  endtask

  task automatic t_trip();
    int h, p;
    duty = 9'd200;
    run_period(h, p, -1, 0, -1, -1);
    run_period(h, p, -1, 0, 20, 25);
    check("R6 trip latency highs", h, 23);
    check("R7 stays off after release", p, 1);
    run_period(h, p, -1, 0, -1, -1);
    check("R7 resumes next period", h, 200);
  endtask

  task automatic t_blocked();
    int h, p;
    duty = 9'd200;
    run_period(h, p, -1, 0, 250, -1);
    check("R8 prior period unaffected", h, 200);
    run_period(h, p, -1, 0, -1, 100);
    check("R8 blocked period", h, 0);
    run_period(h, p, -1, 0, -1, -1);
    check("R8 recovery", h, 200);
  endtask

  task automatic t_fault();
    @(negedge clk);
    oc = 1'b1;
    @(negedge clk);
    check("R9 fault after one clock", int'(fault), 0);
    @(negedge clk);
    check("R9 fault after two clocks", int'(fault), 1);
    oc = 1'b0;
    @(negedge clk);
    check("R9 fault holds one clock", int'(fault), 1);
    @(negedge clk);
    check("R9 fault clears after two", int'(fault), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_strobe_spacing();
    t_duty(100, "R3 d100");
    t_duty(1, "R3 d1");
    t_duty(0, "R4 d0");
    t_full_scale();
    t_one_pulse();
    t_trip();
    t_blocked();
    t_fault();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule